// File: doc/BRIEF.md
# DLL Mode-Switch Sequencer

This block sits on the controller side of a DDR3-style memory interface. It moves the attached device between operation with its delay-locked loop running and operation with the loop bypassed. The clock frequency is changed while the device is held in self-refresh. A single request names the direction. The block then emits, in the required order, mode-register writes, self-refresh entry and exit, an optional long ZQ calibration and, when the loop is being re-enabled, a loop-reset write. Each command is a one-cycle strobe. Between strobes the block enforces programmable wait counts, given as clock cycles on input ports.

The clock itself comes from an outside agent. The sequencer raises `freq_req` once the device is safely in self-refresh. It then waits for `clk_stable` and counts the stable-clock interval before it leaves self-refresh. While a sequence runs, the block drives CKE and can force ODT low. It reports `busy`, then a one-cycle `done`, and shows `ready` whenever it can take a new request.

Top module: `dllsw_seq`

## Requirements
- R1: After reset the block is idle. `ready`=1, `busy`=0, `done`=0, `cke`=1, `freq_req`=0 and `cmd_valid`=0 (opcode NOP=0).
- R2: A disable request (`req_dll_off`=1) produces these strobes, with the listed spacing from each strobe to the next. First MRS (opcode 1) to index 1 with `mr1_val` and bit 0 forced to 1, then tMOD. Then SRE (opcode 2), then tCKSRE, then the clock handshake. Then SRX (opcode 3), then tXS. Then MRS to index 2 with `mr2_val`, then tMRD. Then MRS to index 0 with `mr0_val` and bit 8 forced to 0, then tMOD.
- R3: An enable request (`req_dll_off`=0) produces these strobes. First SRE, then tCKSRE, then the handshake. Then SRX, then tXS. Then MRS index 1 with bit 0 forced to 0, then tMRD. Then MRS index 0 with bit 8 forced to 1 (the loop reset), then tMRD. Then MRS index 2, then tMRD. Then MRS index 0 with bit 8 forced to 0, then tMOD.
- R4: A request starts a sequence only when the block is idle and `idle_ok` is high in the same cycle. Otherwise it produces no strobe and `busy` stays 0.
- R5: A request that arrives while a sequence runs, or in the `done` cycle, is ignored. The command stream and the timing are unchanged, and no second sequence follows.
- R6: `freq_req` rises tCKSRE cycles after the SRE strobe and stays high until `clk_stable` is sampled high. The SRX strobe follows tCKSRX cycles after that sample.
- R7: `cke` is 0 from the SRE strobe cycle through the cycle before the SRX strobe. It is 1 in every other cycle.
- R8: If `odt_feat_en` was high when the request was accepted, `odt` is 0 while `busy` is 1. In all other cycles `odt` follows `odt_in`.
- R9: In an enable sequence, `done` does not come before tDLLK cycles after the loop-reset strobe. It comes at the later of that point and the end of the last wait.
- R10: If `zq_en` was high at acceptance, a ZQCL strobe (opcode 4, index 0, address bit 10 = 1) follows the final tMOD. `done` then comes tZQoper cycles after it.
- R11: `busy` is 1 from the first strobe until `done`. `done` is a one-cycle pulse with `ready`=1, and the block is idle on the next cycle. A wait count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode-switch request |
| req_dll_off | input | 1 | 1 = turn loop off, 0 = turn loop on |
| idle_ok | input | 1 | Banks precharged and termination off |
| zq_en | input | 1 | Issue a long ZQ calibration at the end |
| odt_feat_en | input | 1 | Some termination feature is enabled in the device |
| odt_in | input | 1 | ODT value wanted outside the sequence |
| mr0_val | input | ADDR_W | Final payload for mode register 0 |
| mr1_val | input | ADDR_W | Payload for mode register 1 (bit 0 overwritten) |
| mr2_val | input | ADDR_W | Final payload for mode register 2 |
| t_mod | input | CNT_W | tMOD in cycles |
| t_mrd | input | CNT_W | tMRD in cycles |
| t_xs | input | CNT_W | tXS in cycles |
| t_cksre | input | CNT_W | tCKSRE in cycles |
| t_cksrx | input | CNT_W | tCKSRX in cycles |
| t_dllk | input | CNT_W | tDLLK in cycles |
| t_zqoper | input | CNT_W | tZQoper in cycles |
| clk_stable | input | 1 | New clock stable, from the clock agent |
| freq_req | output | 1 | Ask the clock agent to change frequency |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 3 | Opcode: NOP 0, MRS 1, SRE 2, SRX 3, ZQCL 4 |
| cmd_mr | output | MR_W | Mode-register index |
| cmd_addr | output | ADDR_W | Address payload |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Able to take a request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the wait-count inputs and payloads do not change while `busy` is high. They also assume that the clock agent raises `clk_stable` only after `freq_req` and keeps it high through the SRX strobe. The stimulus fixes all timing inputs before each request and drops `clk_stable` only after a sequence ends. It raises `clk_stable` a chosen number of cycles after `freq_req` goes high. Requests issued during a run or in its `done` cycle test that they are ignored, and a request with `idle_ok` low tests that it is rejected.

// File: rtl/dllsw_pkg.sv
package dllsw_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_MRS  = 3'd1,
      OP_SRE  = 3'd2,
      OP_SRX  = 3'd3,
      OP_ZQCL = 3'd4
   } dllsw_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MR1,
      ST_SRE,
      ST_FREQ,
      ST_CKSRX,
      ST_SRX,
      ST_RST,
      ST_UPD2,
      ST_UPD0,
      ST_ZQ,
      ST_HOLD,
      ST_DONE
   } dllsw_st_e;

   function automatic logic st_is_cmd(dllsw_st_e s);
      return (s == ST_MR1) || (s == ST_SRE) || (s == ST_SRX) || (s == ST_RST) ||
             (s == ST_UPD2) || (s == ST_UPD0) || (s == ST_ZQ);
   endfunction

   function automatic logic st_in_sr(dllsw_st_e s);
      return (s == ST_SRE) || (s == ST_FREQ) || (s == ST_CKSRX);
   endfunction

endpackage

// File: rtl/dllsw_downcnt.sv
module dllsw_downcnt #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);

   if (W < 2) begin : g_bad_width
      $error("dllsw_downcnt: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

endmodule

// File: rtl/dllsw_cmdgen.sv
module dllsw_cmdgen
   import dllsw_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int MR_W        = 2,
   parameter int DLL_OFF_BIT = 0,
   parameter int DLL_RST_BIT = 8,
   parameter int ZQ_LONG_BIT = 10
) (
   input  logic              issue,
   input  dllsw_st_e         st,
   input  logic              dir_off,
   input  logic [ADDR_W-1:0] mr0_v,
   input  logic [ADDR_W-1:0] mr1_v,
   input  logic [ADDR_W-1:0] mr2_v,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [MR_W-1:0]   cmd_mr,
   output logic [ADDR_W-1:0] cmd_addr
);

   localparam logic [MR_W-1:0] IDX_MR0 = MR_W'(0);
   localparam logic [MR_W-1:0] IDX_MR1 = MR_W'(1);
   localparam logic [MR_W-1:0] IDX_MR2 = MR_W'(2);

   if (MR_W < 2) begin : g_bad_mr
      $error("dllsw_cmdgen: MR_W must cover index 2");
   end
   if (DLL_OFF_BIT >= ADDR_W || DLL_RST_BIT >= ADDR_W || ZQ_LONG_BIT >= ADDR_W) begin : g_bad_bits
      $error("dllsw_cmdgen: control bit outside the address payload");
   end

   dllsw_op_e         op;
   logic [MR_W-1:0]   mr;
   logic [ADDR_W-1:0] a;

   always_comb begin
      op = OP_NOP;
      mr = IDX_MR0;
      a  = '0;
      case (st)
         ST_MR1: begin
            op             = OP_MRS;
            mr             = IDX_MR1;
            a              = mr1_v;
            a[DLL_OFF_BIT] = dir_off;
         end
         ST_SRE: op = OP_SRE;
         ST_SRX: op = OP_SRX;
         ST_RST: begin
            op             = OP_MRS;
            mr             = IDX_MR0;
            a              = mr0_v;
            a[DLL_RST_BIT] = 1'b1;
         end
         ST_UPD2: begin
            op = OP_MRS;
            mr = IDX_MR2;
            a  = mr2_v;
         end
         ST_UPD0: begin
            op             = OP_MRS;
            mr             = IDX_MR0;
            a              = mr0_v;
            a[DLL_RST_BIT] = 1'b0;
         end
         ST_ZQ: begin
            op             = OP_ZQCL;
            a[ZQ_LONG_BIT] = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      cmd_valid = issue;
      cmd_op    = issue ? op : OP_NOP;
      cmd_mr    = issue ? mr : '0;
      cmd_addr  = issue ? a  : '0;
   end

endmodule

// File: rtl/dllsw_ctrl.sv
module dllsw_ctrl
   import dllsw_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter bit HAS_ZQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_dll_off,
   input  logic             idle_ok,
   input  logic             zq_en,
   input  logic             odt_feat_en,
   input  logic             clk_stable,
   input  logic [CNT_W-1:0] t_mod,
   input  logic [CNT_W-1:0] t_mrd,
   input  logic [CNT_W-1:0] t_xs,
   input  logic [CNT_W-1:0] t_cksre,
   input  logic [CNT_W-1:0] t_cksrx,
   input  logic [CNT_W-1:0] t_dllk,
   input  logic [CNT_W-1:0] t_zqoper,
   input  logic [CNT_W-1:0] step_cnt,
   input  logic [CNT_W-1:0] dll_cnt,
   output logic             step_load,
   output logic [CNT_W-1:0] step_val,
   output logic             dll_load,
   output logic [CNT_W-1:0] dll_val,
   output dllsw_st_e        st,
   output logic             issue,
   output logic             accept,
   output logic             dir_off,
   output logic             odt_hold,
   output logic             busy
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   dllsw_st_e nxt;
   logic      dir_n;
   logic      zq_use;
   logic      zq_sel;
   logic      last;
   logic      dll_last;
   dllsw_st_e fin;

   if (HAS_ZQ) begin : g_zq
      assign zq_sel = zq_en;
   end else begin : g_no_zq
      assign zq_sel = 1'b0;
   end

   assign last     = (step_cnt <= ONE);
   assign dll_last = (dll_cnt <= ONE);
   assign fin      = dll_last ? ST_DONE : ST_HOLD;
   assign accept   = (st == ST_IDLE) && req_valid && idle_ok;
   assign busy     = (st != ST_IDLE) && (st != ST_DONE);

   always_comb begin
      nxt   = st;
      dir_n = dir_off;
      case (st)
         ST_IDLE:  if (accept) begin
                      dir_n = req_dll_off;
                      nxt   = req_dll_off ? ST_MR1 : ST_SRE;
                   end
         ST_MR1:   if (last) nxt = dir_off ? ST_SRE : ST_RST;
         ST_SRE:   if (last) nxt = ST_FREQ;
         ST_FREQ:  if (clk_stable) nxt = ST_CKSRX;
         ST_CKSRX: if (clk_stable && last) nxt = ST_SRX;
         ST_SRX:   if (last) nxt = dir_off ? ST_UPD2 : ST_MR1;
         ST_RST:   if (last) nxt = ST_UPD2;
         ST_UPD2:  if (last) nxt = ST_UPD0;
         ST_UPD0:  if (last) nxt = zq_use ? ST_ZQ : fin;
         ST_ZQ:    if (last) nxt = fin;
         ST_HOLD:  if (dll_last) nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      step_load = (nxt != st) || ((st == ST_CKSRX) && !clk_stable);
      case (nxt)
         ST_MR1:   step_val = dir_n ? t_mod : t_mrd;
         ST_SRE:   step_val = t_cksre;
         ST_CKSRX: step_val = t_cksrx;
         ST_SRX:   step_val = t_xs;
         ST_RST:   step_val = t_mrd;
         ST_UPD2:  step_val = t_mrd;
         ST_UPD0:  step_val = t_mod;
         ST_ZQ:    step_val = t_zqoper;
         default:  step_val = '0;
      endcase
      dll_load = (nxt == ST_RST) && (st != ST_RST);
      dll_val  = t_dllk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         issue    <= 1'b0;
         dir_off  <= 1'b0;
         zq_use   <= 1'b0;
         odt_hold <= 1'b0;
      end else begin
         st    <= nxt;
         issue <= (nxt != st) && st_is_cmd(nxt);
         if (accept) begin
            dir_off  <= req_dll_off;
            zq_use   <= zq_sel;
            odt_hold <= odt_feat_en;
         end
      end
   end

   // R9: the lock counter has run out whenever completion is signalled
   a_r9_lock_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |-> (dll_cnt == '0));

   // R4: a sequence only begins from an accepted, idle-qualified request
   a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && idle_ok));

endmodule

// File: rtl/dllsw_seq.sv
module dllsw_seq
   import dllsw_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int MR_W        = 2,
   parameter int CNT_W       = 12,
   parameter bit HAS_ZQ      = 1'b1,
   parameter int DLL_OFF_BIT = 0,
   parameter int DLL_RST_BIT = 8,
   parameter int ZQ_LONG_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_dll_off,
   input  logic              idle_ok,
   input  logic              zq_en,
   input  logic              odt_feat_en,
   input  logic              odt_in,
   input  logic [ADDR_W-1:0] mr0_val,
   input  logic [ADDR_W-1:0] mr1_val,
   input  logic [ADDR_W-1:0] mr2_val,
   input  logic [CNT_W-1:0]  t_mod,
   input  logic [CNT_W-1:0]  t_mrd,
   input  logic [CNT_W-1:0]  t_xs,
   input  logic [CNT_W-1:0]  t_cksre,
   input  logic [CNT_W-1:0]  t_cksrx,
   input  logic [CNT_W-1:0]  t_dllk,
   input  logic [CNT_W-1:0]  t_zqoper,
   input  logic              clk_stable,
   output logic              freq_req,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [MR_W-1:0]   cmd_mr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cke,
   output logic              odt,
   output logic              busy,
   output logic              ready,
   output logic              done
);

   if (ADDR_W <= DLL_RST_BIT || ADDR_W <= ZQ_LONG_BIT) begin : g_bad_addr
      $error("dllsw_seq: ADDR_W too narrow for the control bits");
   end

   dllsw_st_e        st;
   logic             issue, accept, dir_off, odt_hold;
   logic             step_load, dll_load;
   logic [CNT_W-1:0] step_val, dll_val, step_cnt, dll_cnt;
   logic [ADDR_W-1:0] mr0_q, mr1_q, mr2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr0_q <= '0;
         mr1_q <= '0;
         mr2_q <= '0;
      end else if (accept) begin
         mr0_q <= mr0_val;
         mr1_q <= mr1_val;
         mr2_q <= mr2_val;
      end
   end

   dllsw_ctrl #(.CNT_W(CNT_W), .HAS_ZQ(HAS_ZQ)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_dll_off(req_dll_off), .idle_ok(idle_ok),
      .zq_en(zq_en), .odt_feat_en(odt_feat_en), .clk_stable(clk_stable),
      .t_mod(t_mod), .t_mrd(t_mrd), .t_xs(t_xs), .t_cksre(t_cksre),
      .t_cksrx(t_cksrx), .t_dllk(t_dllk), .t_zqoper(t_zqoper),
      .step_cnt(step_cnt), .dll_cnt(dll_cnt),
      .step_load(step_load), .step_val(step_val),
      .dll_load(dll_load), .dll_val(dll_val),
      .st(st), .issue(issue), .accept(accept), .dir_off(dir_off),
      .odt_hold(odt_hold), .busy(busy)
   );

   dllsw_downcnt #(.W(CNT_W)) u_step_cnt (
      .clk(clk), .rst_n(rst_n), .load(step_load), .load_val(step_val), .cnt(step_cnt)
   );

   dllsw_downcnt #(.W(CNT_W)) u_dll_cnt (
      .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(dll_val), .cnt(dll_cnt)
   );

   dllsw_cmdgen #(
      .ADDR_W(ADDR_W), .MR_W(MR_W), .DLL_OFF_BIT(DLL_OFF_BIT),
      .DLL_RST_BIT(DLL_RST_BIT), .ZQ_LONG_BIT(ZQ_LONG_BIT)
   ) u_cmdgen (
      .issue(issue), .st(st), .dir_off(dir_off),
      .mr0_v(mr0_q), .mr1_v(mr1_q), .mr2_v(mr2_q),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mr(cmd_mr), .cmd_addr(cmd_addr)
   );

   assign cke      = !st_in_sr(st);
   assign freq_req = (st == ST_FREQ);
   assign ready    = !busy;
   assign done     = (st == ST_DONE);
   assign odt      = (busy && odt_hold) ? 1'b0 : odt_in;

   // R7: self-refresh entry strobe coincides with CKE low
   a_r7_sre_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SRE) |-> !cke);

   // R7: self-refresh exit strobe coincides with CKE high
   a_r7_srx_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SRX) |-> cke);

   // R6: the frequency request only happens inside self-refresh
   a_r6_freq_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
      freq_req |-> (!cke && busy));

   // R11: completion is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

endmodule

// File: tb/tb_dllsw_seq.sv
`timescale 1ns/1ps
module tb_dllsw_seq;

   localparam int ADDR_W = 14;
   localparam int MR_W   = 2;
   localparam int CNT_W  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_dll_off = 1'b0, idle_ok = 1'b1;
   logic zq_en = 1'b0, odt_feat_en = 1'b0, odt_in = 1'b1, clk_stable = 1'b0;
   logic [ADDR_W-1:0] mr0_val = '0, mr1_val = '0, mr2_val = '0;
   logic [CNT_W-1:0]  t_mod = '0, t_mrd = '0, t_xs = '0, t_cksre = '0;
   logic [CNT_W-1:0]  t_cksrx = '0, t_dllk = '0, t_zqoper = '0;
   logic              freq_req, cmd_valid, cke, odt, busy, ready, done;
   logic [2:0]        cmd_op;
   logic [MR_W-1:0]   cmd_mr;
   logic [ADDR_W-1:0] cmd_addr;

   always #2 clk = ~clk;

   dllsw_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dll_off(req_dll_off),
      .idle_ok(idle_ok), .zq_en(zq_en), .odt_feat_en(odt_feat_en), .odt_in(odt_in),
      .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val),
      .t_mod(t_mod), .t_mrd(t_mrd), .t_xs(t_xs), .t_cksre(t_cksre),
      .t_cksrx(t_cksrx), .t_dllk(t_dllk), .t_zqoper(t_zqoper),
      .clk_stable(clk_stable), .freq_req(freq_req), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_mr(cmd_mr), .cmd_addr(cmd_addr), .cke(cke),
      .odt(odt), .busy(busy), .ready(ready), .done(done)
   );

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit wd_hit = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (cyc > 20000 && !wd_hit) begin
         wd_hit = 1'b1;
         failures++;
         $display("FAIL watchdog: run hung at cycle %0d (expected end before 20000)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
      end
   endtask

   function automatic int w(input int t);
      return (t < 1) ? 1 : t;
   endfunction

   // expected event list
   int ev_cyc[$];
   int ev_op[$];
   int ev_mr[$];
   int ev_addr[$];

   task automatic push(input int c, input int op, input int mr, input int a);
      ev_cyc.push_back(c); ev_op.push_back(op); ev_mr.push_back(mr); ev_addr.push_back(a);
   endtask

   task automatic run_seq(input bit off, input bit zq, input bit odtf, input int dly,
                          input bit inject);
      int t0, c, sre, f, e, srx, r, dn, k, done_seen;
      string tag_cmd;
      tag_cmd = off ? "R2" : "R3";
      ev_cyc.delete(); ev_op.delete(); ev_mr.delete(); ev_addr.delete();
      @(negedge clk);
      req_valid = 1'b1; req_dll_off = off; zq_en = zq; odt_feat_en = odtf;
      @(negedge clk);
      req_valid = 1'b0;
      t0 = cyc;
      c = t0; r = 0;
      if (off) begin
         push(c, 1, 1, int'(mr1_val) | 1); c += w(int'(t_mod));
      end
      sre = c; push(c, 2, 0, 0); c += w(int'(t_cksre));
      f = c; e = f + dly + 1; srx = e + w(int'(t_cksrx));
      push(srx, 3, 0, 0); c = srx + w(int'(t_xs));
      if (!off) begin
         push(c, 1, 1, int'(mr1_val) & ~1); c += w(int'(t_mrd));
         r = c; push(c, 1, 0, int'(mr0_val) | (1 << 8)); c += w(int'(t_mrd));
      end
      push(c, 1, 2, int'(mr2_val)); c += w(int'(t_mrd));
      push(c, 1, 0, int'(mr0_val) & ~(1 << 8)); c += w(int'(t_mod));
      if (zq) begin
         push(c, 4, 0, 1 << 10); c += w(int'(t_zqoper));
      end
      dn = c;
      if (!off && (r + int'(t_dllk) > dn)) dn = r + int'(t_dllk);
      done_seen = -1;
      while (cyc <= dn + 2) begin
         bit exp_v, exp_cke, exp_fr, exp_busy, exp_done, exp_odt;
         int eo, em, ea;
         if (cyc == f + dly) clk_stable = 1'b1;
         if (inject && (cyc == t0 + 2 || cyc == dn)) begin
            req_valid = 1'b1; req_dll_off = !off;
         end else begin
            req_valid = 1'b0;
         end
         exp_v = 1'b0; eo = 0; em = 0; ea = 0;
         for (int i = 0; i < ev_cyc.size(); i++)
            if (ev_cyc[i] == cyc) begin
               exp_v = 1'b1; eo = ev_op[i]; em = ev_mr[i]; ea = ev_addr[i];
            end
         exp_cke  = !(cyc >= sre && cyc < srx);
         exp_fr   = (cyc >= f && cyc < e);
         exp_busy = (cyc < dn);
         exp_done = (cyc == dn);
         exp_odt  = (odtf && exp_busy) ? 1'b0 : 1'b1;
         chk(cmd_valid == exp_v && int'(cmd_op) == eo && int'(cmd_mr) == em &&
             int'(cmd_addr) == ea, tag_cmd, "command",
             {cmd_valid, 1'b0, cmd_op, 2'b0, cmd_mr, 2'b0, cmd_addr},
             {exp_v, 1'b0, 3'(eo), 2'b0, 2'(em), 2'b0, 14'(ea)});
         chk(cke == exp_cke, "R7", "cke", cke, exp_cke);
         chk(freq_req == exp_fr, "R6", "freq_req", freq_req, exp_fr);
         chk(busy == exp_busy && done == exp_done && ready == !exp_busy, "R11",
             "busy/done/ready", {busy, done, ready}, {exp_busy, exp_done, !exp_busy});
         chk(odt == exp_odt, "R8", "odt", odt, exp_odt);
         if (done && done_seen < 0) done_seen = cyc;
         @(negedge clk);
      end
      req_valid = 1'b0;
      clk_stable = 1'b0;
      if (!off) chk(done_seen == dn, "R9", "done cycle after loop reset", done_seen, dn);
      if (zq)   chk(done_seen == dn, "R10", "done cycle after ZQCL", done_seen, dn);
      if (inject) begin
         for (int i = 0; i < 8; i++) begin
            chk(!busy && !cmd_valid, "R5", "no restart after ignored request",
                {busy, cmd_valid}, 2'b00);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      mr0_val = 14'h0a70; mr1_val = 14'h0045; mr2_val = 14'h0018;
      t_mod = 12; t_mrd = 4; t_xs = 20; t_cksre = 5; t_cksrx = 6;
      t_dllk = 60; t_zqoper = 30;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ready && !busy && !done && cke && !freq_req && !cmd_valid && cmd_op == 3'd0,
          "R1", "reset outputs", {ready, busy, done, cke, freq_req, cmd_valid},
          6'b100100);

      // R4: request with idle_ok low is rejected
      idle_ok = 1'b0; req_valid = 1'b1; req_dll_off = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!busy && !cmd_valid, "R4", "request without idle_ok", {busy, cmd_valid}, 2'b00);
      end
      req_valid = 1'b0; idle_ok = 1'b1;
      repeat (2) @(negedge clk);

      // disable, termination held, no ZQ, intrusive requests
      run_seq(1'b1, 1'b0, 1'b1, 3, 1'b1);
      repeat (3) @(negedge clk);

      // enable, ZQ, long lock time forces a hold
      t_dllk = 120;
      mr0_val = 14'h1d24; mr1_val = 14'h0006; mr2_val = 14'h0020;
      run_seq(1'b0, 1'b1, 1'b0, 0, 1'b0);
      repeat (3) @(negedge clk);

      // enable, short lock, zero tMRD treated as one
      t_dllk = 5; t_mrd = 0; t_cksre = 1;
      run_seq(1'b0, 1'b0, 1'b1, 7, 1'b1);
      repeat (3) @(negedge clk);

      // disable with ZQ, zero waits elsewhere
      t_mrd = 2; t_xs = 0; t_cksrx = 0; t_mod = 3;
      mr1_val = 14'h3ffe;
      run_seq(1'b1, 1'b1, 1'b0, 1, 1'b0);
      repeat (3) @(negedge clk);

      chk(ready && !busy && cke, "R1", "idle after all runs", {ready, busy, cke}, 3'b101);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule